// File: doc/BRIEF.md
# Maskable Interrupt Reason Controller

This block collects three hardware event pulses from a link-layer command engine and turns them into one interrupt line for a host microcontroller. Each pulse latches a sticky flag in a reason register. A per-flag enable register masks the flags, and the interrupt line is the registered OR of every flag that is both set and enabled. The three flags are: command cleared (bit 0), bus reset (bit 1) and command posted to the micro (bit 2).

Software reaches the block through a small synchronous register port (address, write strobe, write data, combinational read data). The reason register always reads back the raw flags, so software can poll instead of taking the interrupt. Writing ones to the reason register clears those flags. A separate write-only force register sets flags under software control. Only the command-cleared and command-to-micro flags can be forced. The bus-reset flag comes from hardware alone.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, all flags and enables are 0, every register reads 0, and `irq` is 0.
- R2: A one-cycle pulse on `ev_cmd_clr`, `ev_bus_reset` or `ev_cmd_micro` sets reason bit 0, 1 or 2 respectively at the next clock edge. The flag then stays set until it is cleared.
- R3: A read of the reason register (address 0x1) returns the raw flags in bits 2:0, whatever the enable register holds.
- R4: The enable register (address 0x0) stores bits 2:0 of a write and reads them back. A read from any address other than 0x0 or 0x1 returns 0.
- R5: `irq` is 1 exactly when, at the previous clock edge, some reason bit and its matching enable bit were both 1.
- R6: Writing the reason register clears each flag whose write-data bit is 1. Flags whose write-data bit is 0 are left unchanged.
- R7: If an event pulse and a clear write hit the same flag in the same cycle, the flag ends up set.
- R8: Writing the force register (address 0x2) sets reason bit 0 and/or bit 2 wherever the write-data bit is 1. Zero bits have no effect.
- R9: Through the force register, write-data bit 1 and bits 7:3 have no effect. In particular, the bus-reset flag cannot be set from software.
- R10: Reserved bits 7:3 of the reason and enable registers read 0 and ignore writes. The force register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (4) | Register address |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | DATA_W (8) | Write data |
| rd_data | output | DATA_W (8) | Combinational read data of the addressed register |
| ev_cmd_clr | input | 1 | Command-cleared event pulse |
| ev_bus_reset | input | 1 | Bus-reset event pulse |
| ev_cmd_micro | input | 1 | Command-to-micro event pulse |
| irq | output | 1 | Registered, masked interrupt request |

## Verification
A corrupted flag shows up at the reason read port in the cycle after the bad edge. If that flag is enabled, it also shows up on `irq` one edge later. A corrupted enable bit stays hidden on `irq` until its flag is set, but it is visible at once on a read of address 0x0. The bench therefore compares read data and `irq` against a behavioural model on every clock. It also mixes random traffic with directed collisions between events and clears, so that a stuck or misrouted bit shows up within a few cycles.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
   localparam int NUM_FLAGS  = 3;
   localparam int FLAG_CLR   = 0;
   localparam int FLAG_BUS   = 1;
   localparam int FLAG_MICRO = 2;

   // flags that the force register may set
   localparam logic [NUM_FLAGS-1:0] FORCE_MASK =
      NUM_FLAGS'((1 << FLAG_CLR) | (1 << FLAG_MICRO));

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_ENABLE = 2'd1,
      SEL_REASON = 2'd2,
      SEL_FORCE  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/evt_reg_decode.sv
module evt_reg_decode
   import evt_irq_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int ENABLE_ADDR = 0,
   parameter int REASON_ADDR = 1,
   parameter int FORCE_ADDR  = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   output reg_sel_e          sel,
   output logic              wr_enable,
   output logic              wr_reason,
   output logic              wr_force
);
   localparam int ADDR_SPAN = 1 << ADDR_W;

   if (ENABLE_ADDR >= ADDR_SPAN || REASON_ADDR >= ADDR_SPAN || FORCE_ADDR >= ADDR_SPAN) begin : g_bad_range
      $error("evt_reg_decode: register address outside ADDR_W range");
   end
   if (ENABLE_ADDR == REASON_ADDR || ENABLE_ADDR == FORCE_ADDR || REASON_ADDR == FORCE_ADDR) begin : g_bad_overlap
      $error("evt_reg_decode: register addresses must be distinct");
   end

   always_comb begin
      sel = SEL_NONE;
      if (addr == ADDR_W'(ENABLE_ADDR)) begin
         sel = SEL_ENABLE;
      end else if (addr == ADDR_W'(REASON_ADDR)) begin
         sel = SEL_REASON;
      end else if (addr == ADDR_W'(FORCE_ADDR)) begin
         sel = SEL_FORCE;
      end
   end

   always_comb begin
      wr_enable = wr_en && (sel == SEL_ENABLE);
      wr_reason = wr_en && (sel == SEL_REASON);
      wr_force  = wr_en && (sel == SEL_FORCE);
   end
endmodule

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
   parameter int                  NF         = 3,
   parameter logic [NF-1:0]       FORCE_MASK = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] events,
   input  logic          clr_wr,
   input  logic [NF-1:0] clr_bits,
   input  logic          force_wr,
   input  logic [NF-1:0] force_bits,
   output logic [NF-1:0] flags
);
   if (NF < 1) begin : g_bad_nf
      $error("evt_flag_bank: NF must be at least 1");
   end

   for (genvar i = 0; i < NF; i++) begin : g_flag
      logic q;
      logic force_hit;

      if (FORCE_MASK[i]) begin : g_forceable
         assign force_hit = force_wr & force_bits[i];
      end else begin : g_hw_only
         logic unused_force;
         assign unused_force = force_bits[i];
         assign force_hit    = 1'b0;
      end

      // set sources take priority over a clear in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= 1'b0;
         end else if (events[i] || force_hit) begin
            q <= 1'b1;
         end else if (clr_wr && clr_bits[i]) begin
            q <= 1'b0;
         end
      end

      assign flags[i] = q;
   end
endmodule

// File: rtl/evt_enable_reg.sv
module evt_enable_reg #(
   parameter int NF = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [NF-1:0] wdata,
   output logic [NF-1:0] en_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (wr) begin
         en_q <= wdata;
      end
   end
endmodule

// File: rtl/evt_irq_combine.sv
module evt_irq_combine #(
   parameter int NF         = 3,
   parameter bit REGISTERED = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] flags,
   input  logic [NF-1:0] enables,
   output logic          irq
);
   logic pending;
   assign pending = |(flags & enables);

   if (REGISTERED) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_q <= 1'b0;
         end else begin
            irq_q <= pending;
         end
      end
      assign irq = irq_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq        = pending;
   end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
   import evt_irq_pkg::*;
#(
   parameter int ADDR_W         = 4,
   parameter int DATA_W         = 8,
   parameter int ENABLE_ADDR    = 0,
   parameter int REASON_ADDR    = 1,
   parameter int FORCE_ADDR     = 2,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              ev_cmd_clr,
   input  logic              ev_bus_reset,
   input  logic              ev_cmd_micro,
   output logic              irq
);
   localparam int NF = NUM_FLAGS;

   if (DATA_W < NF) begin : g_bad_width
      $error("evt_irq_ctrl: DATA_W narrower than the flag set");
   end

   reg_sel_e      sel;
   logic          wr_enable, wr_reason, wr_force;
   logic [NF-1:0] ev_vec;
   logic [NF-1:0] flag_q;
   logic [NF-1:0] enable_q;
   logic [NF-1:0] wr_low;
   logic          unused_wr_hi;

   assign wr_low       = wr_data[NF-1:0];
   assign unused_wr_hi = ^wr_data;

   always_comb begin
      ev_vec             = '0;
      ev_vec[FLAG_CLR]   = ev_cmd_clr;
      ev_vec[FLAG_BUS]   = ev_bus_reset;
      ev_vec[FLAG_MICRO] = ev_cmd_micro;
   end

   evt_reg_decode #(
      .ADDR_W      (ADDR_W),
      .ENABLE_ADDR (ENABLE_ADDR),
      .REASON_ADDR (REASON_ADDR),
      .FORCE_ADDR  (FORCE_ADDR)
   ) u_decode (
      .addr      (addr),
      .wr_en     (wr_en),
      .sel       (sel),
      .wr_enable (wr_enable),
      .wr_reason (wr_reason),
      .wr_force  (wr_force)
   );

   evt_flag_bank #(
      .NF         (NF),
      .FORCE_MASK (FORCE_MASK)
   ) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .events     (ev_vec),
      .clr_wr     (wr_reason),
      .clr_bits   (wr_low),
      .force_wr   (wr_force),
      .force_bits (wr_low),
      .flags      (flag_q)
   );

   evt_enable_reg #(
      .NF (NF)
   ) u_enable (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_enable),
      .wdata (wr_low),
      .en_q  (enable_q)
   );

   evt_irq_combine #(
      .NF         (NF),
      .REGISTERED (IRQ_REGISTERED)
   ) u_combine (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags   (flag_q),
      .enables (enable_q),
      .irq     (irq)
   );

   always_comb begin
      rd_data = '0;
      unique case (sel)
         SEL_ENABLE: rd_data[NF-1:0] = enable_q;
         SEL_REASON: rd_data[NF-1:0] = flag_q;
         default:    rd_data         = '0;
      endcase
   end
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
   parameter int ADDR_W         = 4,
   parameter int DATA_W         = 8,
   parameter int REASON_ADDR    = 1,
   parameter int FORCE_ADDR     = 2,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic              ev_cmd_clr,
   input logic              ev_bus_reset,
   input logic              ev_cmd_micro,
   input logic              irq,
   input logic [2:0]        flag_q,
   input logic [2:0]        enable_q
);
   logic hit_reason, hit_force, any_ev;
   assign hit_reason = wr_en && (addr == ADDR_W'(REASON_ADDR));
   assign hit_force  = wr_en && (addr == ADDR_W'(FORCE_ADDR));
   assign any_ev     = ev_cmd_clr | ev_bus_reset | ev_cmd_micro;

   if (IRQ_REGISTERED) begin : g_irq_reg
      p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (|(flag_q & enable_q)) |=> irq);
      p_irq_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
         !(|(flag_q & enable_q)) |=> !irq);
   end

   p_bus_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_bus_reset |=> flag_q[1]);
   p_micro_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_cmd_micro |=> flag_q[2]);
   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_reason && wr_data[2] && !ev_cmd_micro) |=> !flag_q[2]);
   p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_reason && wr_data[0] && ev_cmd_clr) |=> flag_q[0]);
   p_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_force && wr_data[0]) |=> flag_q[0]);
   p_no_bus_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_bus_reset && !flag_q[1]) |=> !flag_q[1]);
   p_quiet_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !any_ev) |=> $stable(flag_q));
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(
   .ADDR_W         (ADDR_W),
   .DATA_W         (DATA_W),
   .REASON_ADDR    (REASON_ADDR),
   .FORCE_ADDR     (FORCE_ADDR),
   .IRQ_REGISTERED (IRQ_REGISTERED)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .addr         (addr),
   .wr_en        (wr_en),
   .wr_data      (wr_data),
   .ev_cmd_clr   (ev_cmd_clr),
   .ev_bus_reset (ev_bus_reset),
   .ev_cmd_micro (ev_cmd_micro),
   .irq          (irq),
   .flag_q       (flag_q),
   .enable_q     (enable_q)
);

// File: tb/evt_irq_ctrl_bench.sv
`timescale 1ns/1ps
module evt_irq_ctrl_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       ev_cmd_clr = 1'b0, ev_bus_reset = 1'b0, ev_cmd_micro = 1'b0;
   logic       irq;

   int checks = 0;
   int errors = 0;
   int m_reason = 0, m_en = 0, m_irq = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   evt_irq_ctrl u_evt_irq_ctrl (
      .clk (clk), .rst_n (rst_n), .addr (addr), .wr_en (wr_en),
      .wr_data (wr_data), .rd_data (rd_data), .ev_cmd_clr (ev_cmd_clr),
      .ev_bus_reset (ev_bus_reset), .ev_cmd_micro (ev_cmd_micro), .irq (irq)
   );

   task automatic check(input int act, input int exp, input string tag, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic int model_read(input int a);
      if (a == 0) return m_en;
      if (a == 1) return m_reason;
      return 0;
   endfunction

   // one clock: drive at the falling edge, check read data, model the edge, check irq
   task automatic step(input int a, input bit w, input int d, input int ev);
      int nr;
      addr = 4'(a); wr_en = w; wr_data = 8'(d);
      ev_cmd_clr = ev[0]; ev_bus_reset = ev[1]; ev_cmd_micro = ev[2];
      #1;
      check(int'(rd_data), model_read(a), (a == 1) ? "R3" : ((a == 0) ? "R4" : "R10"), "read data");
      @(posedge clk);
      m_irq = ((m_reason & m_en) != 0) ? 1 : 0;
      nr = m_reason;
      if (w && a == 1) nr = nr & ~(d & 7);
      if (w && a == 2) nr = nr | (d & 5);
      nr = nr | (ev & 7);
      if (w && a == 0) m_en = d & 7;
      m_reason = nr;
      @(negedge clk);
      wr_en = 1'b0; ev_cmd_clr = 1'b0; ev_bus_reset = 1'b0; ev_cmd_micro = 1'b0;
      check(int'(irq), m_irq, "R5", "irq vs model");
   endtask

   task automatic expect_read(input int a, input int exp, input string tag);
      addr = 4'(a); wr_en = 1'b0;
      #1;
      check(int'(rd_data), exp, tag, "directed read");
      step(a, 1'b0, 0, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog R1: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(int'(irq), 0, "R1", "irq after reset");
      expect_read(0, 0, "R1");
      expect_read(1, 0, "R1");
      expect_read(2, 0, "R1");
      // R2 events latch into their own bits
      step(1, 0, 0, 3'b001); expect_read(1, 8'h01, "R2");
      step(1, 0, 0, 3'b010); expect_read(1, 8'h03, "R2");
      step(1, 0, 0, 3'b100); expect_read(1, 8'h07, "R2");
      // R3 unmasked read with all enables off; R5 no irq
      expect_read(1, 8'h07, "R3");
      check(int'(irq), 0, "R5", "irq with enables off");
      // R10 reserved enable bits; R5 one-cycle latency
      step(0, 1, 8'hFF, 0);
      check(int'(irq), 0, "R5", "irq one edge after enable write");
      expect_read(0, 8'h07, "R10");
      check(int'(irq), 1, "R5", "irq two edges after enable write");
      // R6 clear by ones, zeros ignored
      step(1, 1, 8'h01, 0); expect_read(1, 8'h06, "R6");
      step(1, 1, 8'h00, 0); expect_read(1, 8'h06, "R6");
      step(1, 1, 8'hFF, 0); expect_read(1, 8'h00, "R6");
      check(int'(irq), 0, "R5", "irq after full clear");
      // R7 event beats clear
      step(1, 1, 8'h02, 3'b010); expect_read(1, 8'h02, "R7");
      step(1, 1, 8'h02, 0); expect_read(1, 8'h00, "R6");
      // R8 / R9 force register
      step(2, 1, 8'hFF, 0); expect_read(1, 8'h05, "R8");
      step(2, 1, 8'h00, 0); expect_read(1, 8'h05, "R8");
      step(1, 1, 8'hFF, 0);
      step(2, 1, 8'hFA, 0); expect_read(1, 8'h00, "R9");
      expect_read(2, 8'h00, "R10");
      // R4 enable storage and unmapped reads
      step(0, 1, 8'h02, 0); expect_read(0, 8'h02, "R4");
      expect_read(3, 8'h00, "R4");
      expect_read(15, 8'h00, "R4");
      step(1, 0, 0, 3'b001); step(1, 0, 0, 0);
      check(int'(irq), 0, "R5", "masked flag keeps irq low");
      // random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         int a, ev;
         a  = $urandom_range(0, 4);
         ev = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 7)) : 0;
         step(a, $urandom_range(0, 2) == 0, int'($urandom_range(0, 255)), ev);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule